// File: doc/BRIEF.md
# Display Scanline Position Counter

This block tracks the vertical position of a display pipe. A raw line counter moves forward once for each rising edge of horizontal sync. It wraps at the effective vertical total. That total is the programmed value, or half of it when the pipe scans interlaced fields.

Next to the raw count, the block reports a corrected line number. The raw counter does not start at zero on the first active line. Where it does start depends on the counter convention and on the kind of output attached. A mode-set strobe captures a correction offset that suits the current configuration. The block then reports `(raw + offset) mod effectiveTotal`, held in a register one clock after the raw value it comes from.

Software or a vblank-timing unit reads the corrected value to learn which line is being scanned, with no per-read arithmetic.

Top module: `scanline_counter`

## Requirements
- R1: `rawLine` increases by exactly one on each clock edge at which `hsyncIn` is high after being low on the previous edge. A high level held for many cycles advances it only once.
- R2: When an advance would make `rawLine` equal to the effective total, `rawLine` becomes 0 instead.
- R3: With `interlaced` = 1, the effective total is `vTotal` shifted right by one (rounded down), both for wrapping and for the offset captured in legacy mode. With `interlaced` = 0, it is `vTotal`.
- R4: A mode set with `legacyMode` = 0 and `outIsHdmi` = 0 (DP-style output) captures an offset of 1.
- R5: A mode set with `legacyMode` = 0 and `outIsHdmi` = 1 captures an offset of 2.
- R6: A mode set with `legacyMode` = 1 captures an offset of effective total minus 1, whatever `outIsHdmi` is. Line 0 of the raw count then reports as effective total minus 1.
- R7: The offset changes only on a clock edge with `modeSet` = 1. Changing `legacyMode`, `outIsHdmi` or `interlaced` without a mode set leaves the corrected readout using the old offset.
- R8: `lineOut` equals `(rawLine + offset) mod effectiveTotal`, computed from the values held before a clock edge and presented after that edge.
- R9: While `rst_n` is low, `rawLine` and `lineOut` are 0 and the offset is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsyncIn | input | 1 | Horizontal sync level, active high |
| vTotal | input | LINE_W | Programmed vertical total in lines |
| interlaced | input | 1 | Halves the effective vertical total |
| legacyMode | input | 1 | Selects the counter convention that starts at 1 |
| outIsHdmi | input | 1 | 1 = HDMI output, 0 = DP-style output |
| modeSet | input | 1 | One-cycle strobe that captures the offset |
| rawLine | output | LINE_W | Uncorrected line counter |
| lineOut | output | LINE_W | Corrected line number |

## Verification
The bench holds sync high for several cycles to catch a level-sensitive counter, which would run through many lines per sync pulse. It drives the raw count across its wrap with each offset. A missing modulo, or a modulo done against the unhalved total in interlaced mode, then shows up as a line number at or above the total. It swaps the output-type and legacy selects without a mode set, which exposes an offset recomputed live rather than latched. It checks that legacy raw line 0 reads as the last line, which an add-one design reports as line 1.

// File: rtl/scanline_pkg.sv
package scanline_pkg;
  // Strobes from the control module to the datapath
  typedef struct packed {
    logic advance;  // rising hsync seen this cycle
    logic load;     // capture the correction offset
  } lineCtl_t;
endpackage

// File: rtl/scanline_ctrl.sv
module scanline_ctrl
  import scanline_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hsyncIn,
  input  logic     modeSet,
  output lineCtl_t ctl
);
  logic hsyncQ;

  always_ff @(posedge clk) begin
    if (!rst_n) hsyncQ <= 1'b0;
    else        hsyncQ <= hsyncIn;
  end

  always_comb begin
    ctl.advance = hsyncIn & ~hsyncQ;
    ctl.load    = modeSet;
  end

  // R1
  single_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.advance |=> !ctl.advance);
endmodule

// File: rtl/scanline_dp.sv
module scanline_dp
  import scanline_pkg::*;
#(
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lineCtl_t          ctl,
  input  logic [LINE_W-1:0] vTotal,
  input  logic              interlaced,
  input  logic              legacyMode,
  input  logic              outIsHdmi,
  output logic [LINE_W-1:0] rawLine,
  output logic [LINE_W-1:0] lineOut
);
  localparam int SUM_W = LINE_W + 1;
  localparam logic [LINE_W-1:0] OFF_DP   = LINE_W'(1);
  localparam logic [LINE_W-1:0] OFF_HDMI = LINE_W'(2);

  logic [LINE_W-1:0] vtEff, offset, offNext;
  logic [SUM_W-1:0]  rawInc, corrSum, corrWrap, vtWide;

  always_comb begin
    vtEff    = interlaced ? (vTotal >> 1) : vTotal;
    vtWide   = {1'b0, vtEff};
    rawInc   = {1'b0, rawLine} + SUM_W'(1);
    corrSum  = {1'b0, rawLine} + {1'b0, offset};
    // raw < vtEff and offset < vtEff, so one subtract is a full modulo
    corrWrap = (corrSum >= vtWide) ? (corrSum - vtWide) : corrSum;
    if (legacyMode)     offNext = vtEff - LINE_W'(1);
    else if (outIsHdmi) offNext = OFF_HDMI;
    else                offNext = OFF_DP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rawLine <= '0;
      offset  <= OFF_DP;
      lineOut <= '0;
    end else begin
      if (ctl.advance)
        rawLine <= (rawInc >= vtWide) ? '0 : rawInc[LINE_W-1:0];
      if (ctl.load)
        offset <= offNext;
      lineOut <= corrWrap[LINE_W-1:0];
    end
  end

  // R1
  raw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.advance |=> $stable(rawLine));
  // R1
  raw_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.advance && rawInc < vtWide) |=> rawLine == $past(rawLine) + LINE_W'(1));
  // R2
  raw_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.advance && rawInc >= vtWide) |=> rawLine == '0);
  // R7
  offset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.load |=> $stable(offset));
endmodule

// File: rtl/scanline_counter.sv
module scanline_counter
  import scanline_pkg::*;
#(
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsyncIn,
  input  logic [LINE_W-1:0] vTotal,
  input  logic              interlaced,
  input  logic              legacyMode,
  input  logic              outIsHdmi,
  input  logic              modeSet,
  output logic [LINE_W-1:0] rawLine,
  output logic [LINE_W-1:0] lineOut
);
  lineCtl_t ctl;

  scanline_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .hsyncIn (hsyncIn),
    .modeSet (modeSet),
    .ctl     (ctl)
  );

  scanline_dp #(.LINE_W(LINE_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .vTotal     (vTotal),
    .interlaced (interlaced),
    .legacyMode (legacyMode),
    .outIsHdmi  (outIsHdmi),
    .rawLine    (rawLine),
    .lineOut    (lineOut)
  );
endmodule

// File: tb/tb_scanline_counter.sv
module tb_scanline_counter;
  localparam int LINE_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsyncIn = 1'b0;
  logic [LINE_W-1:0] vTotal = LINE_W'(10);
  logic interlaced = 1'b0;
  logic legacyMode = 1'b0;
  logic outIsHdmi = 1'b0;
  logic modeSet = 1'b0;
  logic [LINE_W-1:0] rawLine, lineOut;

  always #10 clk = ~clk;  // 50 MHz

  scanline_counter #(.LINE_W(LINE_W)) dut (
    .clk(clk), .rst_n(rst_n), .hsyncIn(hsyncIn), .vTotal(vTotal),
    .interlaced(interlaced), .legacyMode(legacyMode), .outIsHdmi(outIsHdmi),
    .modeSet(modeSet), .rawLine(rawLine), .lineOut(lineOut)
  );

  int vecs = 0, fails = 0;
  string req = "R9";
  int mRaw, mOff, mLine, mPrevHs;

  function automatic int effOf(int vt, bit il);
    return il ? vt / 2 : vt;
  endfunction

  function automatic int offOf(int vt, bit il, bit leg, bit hdmi);
    if (leg) return effOf(vt, il) - 1;  // R6
    return hdmi ? 2 : 1;                // R5 / R4
  endfunction

  function automatic int corr(int raw, int off, int eff);
    return (raw + off) % eff;           // R8
  endfunction

  task automatic chk(string tag, int act, int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0; hsyncIn = 1'b0; modeSet = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    mRaw = 0; mOff = 1; mLine = 0; mPrevHs = 0;
    // R9 reset state
    chk("R9 raw", int'(rawLine), 0);
    chk("R9 line", int'(lineOut), 0);
  endtask

  task automatic cycle(bit hs, bit ms);
    int eff, nl;
    @(negedge clk);
    hsyncIn = hs; modeSet = ms;
    @(posedge clk);
    eff = effOf(int'(vTotal), interlaced);
    nl = corr(mRaw, mOff, eff);
    if (hs && !mPrevHs) mRaw = (mRaw + 1 >= eff) ? 0 : mRaw + 1;
    if (ms) mOff = offOf(int'(vTotal), interlaced, legacyMode, outIsHdmi);
    mPrevHs = int'(hs); mLine = nl;
    #5;
    chk({req, " raw"}, int'(rawLine), mRaw);
    chk({req, " R8 line"}, int'(lineOut), mLine);
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin cycle(1'b1, 1'b0); cycle(1'b0, 1'b0); end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    vTotal = LINE_W'(10);
    doReset();
    req = "R9";
    cycle(1'b0, 1'b0);  // reset offset 1 -> line 1
    chk("R9 offset", int'(lineOut), 1);

    // R1: held high level advances once
    req = "R1";
    cycle(1'b1, 1'b0);
    for (int i = 0; i < 6; i++) cycle(1'b1, 1'b0);
    chk("R1 held", int'(rawLine), 1);
    cycle(1'b0, 1'b0);

    // R4 DP offset, through R2 wrap
    req = "R4"; outIsHdmi = 1'b0; legacyMode = 1'b0;
    cycle(1'b0, 1'b1);
    req = "R2"; pulses(23);

    // R5 HDMI offset
    req = "R5"; outIsHdmi = 1'b1;
    cycle(1'b0, 1'b1);
    pulses(21);

    // R6 legacy: raw 0 reads as last line
    req = "R6"; legacyMode = 1'b1;
    cycle(1'b0, 1'b1);
    while (mRaw != 0) pulses(1);
    cycle(1'b0, 1'b0);
    chk("R6 line0", int'(lineOut), 9);
    pulses(12);

    // R7: selects change without mode set
    req = "R7"; legacyMode = 1'b0; outIsHdmi = 1'b0;
    pulses(4);
    while (mRaw != 0) pulses(1);
    cycle(1'b0, 1'b0);
    chk("R7 kept", int'(lineOut), 9);

    // R3 interlaced, odd total 11 -> 5
    vTotal = LINE_W'(11); interlaced = 1'b1; legacyMode = 1'b1;
    doReset();
    req = "R3";
    cycle(1'b0, 1'b1);
    pulses(5);
    chk("R3 wrap", int'(rawLine), 0);
    cycle(1'b0, 1'b0);
    chk("R3 off", int'(lineOut), 4);
    pulses(7);

    // Random phases
    void'($urandom(32'h5C4A_11E0));
    for (int p = 0; p < 24; p++) begin
      vTotal = LINE_W'(4 + ($urandom % 60));
      interlaced = 1'($urandom); legacyMode = 1'($urandom); outIsHdmi = 1'($urandom);
      doReset();
      req = "R8";
      cycle(1'b0, 1'b1);
      for (int c = 0; c < 250; c++) begin
        if (($urandom % 40) == 0) begin
          legacyMode = 1'($urandom); outIsHdmi = 1'($urandom);
        end
        cycle(1'(($urandom % 3) == 0), 1'(($urandom % 50) == 0));
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule